// File: doc/BRIEF.md
# Page-Splitting Chained DMA Engine

This block moves a run of 32-bit words between memory and a device word port with no processor involvement. Software fills in a start address, a byte count and a direction through a small register window, then sets a go bit. From then on the engine issues word-by-word memory requests on a request/grant port and feeds or drains a ready/valid device port. The addresses it issues are physical. Cache coherence is not handled here.

A burst never crosses a 4096-byte page. A region that straddles a page edge is therefore cut into page-bounded bursts. The first beat of each burst is flagged, and it carries that burst's word count. With chain mode set, the engine walks a four-entry internal descriptor table. Scattered physical regions are then serviced as one operation. A single level interrupt reports either the end of the whole operation or an error. Software clears it by writing 1 to the status bit that caused it.

Register word offsets:

| Offset | Name | Fields |
|---|---|---|
| 0 | CTRL | bit0 go, bit1 dir (0 = memory to device, 1 = device to memory), bit2 chain |
| 1 | STATUS | bit0 busy, bit1 done, bit2 error, bit3 overrun; bits 1 to 3 are write-1-to-clear |
| 2 | SRC_ADDR | start address for single mode |
| 3 | SRC_LEN | byte count for single mode |
| 4 | MOVED | words moved since the last start |
| 8+2i | entry i address | start address of descriptor i |
| 9+2i | entry i length | byte count in bits [15:0], stop flag in bit31 |

Top module: `dma_chain_top`

## Requirements
- R1: After reset, STATUS reads 0, `irq` is low, and neither `mem_req` nor `dev_out_valid` is asserted.
- R2: With dir=0, the engine reads consecutive words starting at the word-aligned start address and presents each word on `dev_out_data`, in address order. Once the operation ends, MOVED holds the number of words transferred. `mem_addr`/`mem_we` stay stable while `mem_req` waits for `mem_gnt`, and `dev_out_data` stays stable while `dev_out_ready` is low.
- R3: With dir=1, each word accepted from `dev_in_data` is written to memory at consecutive word addresses, in arrival order.
- R4: No burst crosses a 4096-byte boundary. Each burst's length is the smaller of the words remaining and the words left to the next page boundary. Its first beat has `mem_first`=1, with that length on `mem_blen`.
- R5: In chain mode the engine services entries 0, 1, 2, 3 in order. It stops after an entry whose stop flag (bit31 of its length word) is set, or after entry 3. Single mode (chain=0) uses SRC_ADDR/SRC_LEN as one entry.
- R6: When the last entry completes, STATUS bit1 (done) is set, bit0 (busy) reads 0, and `irq` rises.
- R7: A beat granted with `mem_err`=1 stops the engine at once. STATUS bit2 (error) is set, `irq` rises, done stays clear, and no further memory request follows.
- R8: An entry whose byte count holds fewer than 4 bytes (zero words) raises the error bit and `irq` without issuing any memory request.
- R9: `irq` stays high until software writes 1 to STATUS bit1 or bit2 for every set bit. It then falls.
- R10: A go write while busy is ignored: the running operation is unaffected and no extra transfer starts. It sets STATUS bit3 (overrun), which stays set until written with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| irq | output | 1 | Level interrupt: done or error pending |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_first | output | 1 | First beat of a burst |
| mem_blen | output | 15 | Word count of the current burst |
| mem_gnt | input | 1 | Beat accepted this cycle |
| mem_err | input | 1 | Error response, valid with `mem_gnt` |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` |
| dev_out_valid | output | 1 | Word offered to the device |
| dev_out_data | output | 32 | Word to the device |
| dev_out_ready | input | 1 | Device takes the word |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_data | input | 32 | Word from the device |
| dev_in_ready | output | 1 | Engine takes the word |

## Verification
The bench builds the block with its defaults: a 4096-byte page, a 16-bit byte count and four descriptor entries. Start addresses are placed a few words below a page edge. Short transfers therefore cross a boundary, which makes the split and the per-burst length visible within a handful of beats. Four entries are enough for a chain that stops on an early stop flag with a valid-looking spare entry behind it. Irregular grant and ready patterns keep both stall-hold rules in play.

// File: rtl/dma_pkg.sv
package dma_pkg;
    // register word offsets
    localparam int OFS_CTRL  = 0;
    localparam int OFS_STAT  = 1;
    localparam int OFS_ADDR  = 2;
    localparam int OFS_LEN   = 3;
    localparam int OFS_CNT   = 4;
    localparam int OFS_DESC  = 8;
    // control bits
    localparam int CTL_GO    = 0;
    localparam int CTL_DIR   = 1;
    localparam int CTL_CHAIN = 2;
    // status bits
    localparam int ST_BUSY   = 0;
    localparam int ST_DONE   = 1;
    localparam int ST_ERR    = 2;
    localparam int ST_OVR    = 3;
    // stop flag in an entry length word
    localparam int DSC_STOP  = 31;

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_CHUNK, S_RD, S_DOUT, S_DIN, S_WR, S_NEXT
    } eng_state_t;
endpackage

// File: rtl/dma_chunk.sv
// Words that may go in one burst: min(remaining, words to page edge).
module dma_chunk #(
    parameter int OFS_W = 10,
    parameter int WC_W  = 15
) (
    input  logic [OFS_W-1:0] page_ofs,
    input  logic [WC_W-1:0]  rem_words,
    output logic [WC_W-1:0]  chunk_words
);
    localparam int PAGE_WORDS = 1 << OFS_W;
    localparam int CW = (WC_W > OFS_W + 1) ? WC_W : OFS_W + 1;

    logic [CW-1:0] to_edge_d;
    logic [CW-1:0] rem_x_d;

    assign to_edge_d   = CW'(PAGE_WORDS) - CW'(page_ofs);
    assign rem_x_d     = CW'(rem_words);
    assign chunk_words = (rem_x_d < to_edge_d) ? rem_words : WC_W'(to_edge_d);

    always_comb begin
        a_r4_chunk_fits: assert (CW'(page_ofs) + CW'(chunk_words) <= CW'(PAGE_WORDS));
    end
endmodule

// File: rtl/dma_regs.sv
module dma_regs #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DESC_N = 4,
    parameter int IDX_W  = 2,
    parameter int REG_AW = 4,
    parameter int CNT_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              busy,
    input  logic              done_set,
    input  logic              err_set,
    input  logic [CNT_W-1:0]  moved,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic              chain_mode,
    output logic              start,
    output logic              start_dir,
    output logic              start_chain,
    output logic [ADDR_W-1:0] d_addr,
    output logic [LEN_W-1:0]  d_len,
    output logic              d_stop,
    output logic              irq
);
    import dma_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              done;
        logic              err;
        logic              ovr;
    } regs_t;

    regs_t             r_d, r_q;
    logic [ADDR_W-1:0] da_d [DESC_N];
    logic [ADDR_W-1:0] da_q [DESC_N];
    logic [LEN_W-1:0]  dl_d [DESC_N];
    logic [LEN_W-1:0]  dl_q [DESC_N];
    logic              dk_d [DESC_N];
    logic              dk_q [DESC_N];

    always_comb begin
        r_d         = r_q;
        da_d        = da_q;
        dl_d        = dl_q;
        dk_d        = dk_q;
        start       = 1'b0;
        start_dir   = cfg_wdata[CTL_DIR];
        start_chain = cfg_wdata[CTL_CHAIN];
        if (cfg_wr) begin
            if (cfg_addr == REG_AW'(OFS_CTRL)) begin
                if (!busy)                   start = cfg_wdata[CTL_GO];
                else if (cfg_wdata[CTL_GO]) r_d.ovr = 1'b1;
            end
            if (cfg_addr == REG_AW'(OFS_STAT)) begin
                if (cfg_wdata[ST_DONE]) r_d.done = 1'b0;
                if (cfg_wdata[ST_ERR])  r_d.err  = 1'b0;
                if (cfg_wdata[ST_OVR])  r_d.ovr  = 1'b0;
            end
            if (cfg_addr == REG_AW'(OFS_ADDR)) r_d.addr = cfg_wdata[ADDR_W-1:0];
            if (cfg_addr == REG_AW'(OFS_LEN))  r_d.len  = cfg_wdata[LEN_W-1:0];
            for (int i = 0; i < DESC_N; i++) begin
                if (cfg_addr == REG_AW'(OFS_DESC + 2*i)) da_d[i] = cfg_wdata[ADDR_W-1:0];
                if (cfg_addr == REG_AW'(OFS_DESC + 2*i + 1)) begin
                    dl_d[i] = cfg_wdata[LEN_W-1:0];
                    dk_d[i] = cfg_wdata[DSC_STOP];
                end
            end
        end
        // engine events win over a same-cycle clear
        if (done_set) r_d.done = 1'b1;
        if (err_set)  r_d.err  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int i = 0; i < DESC_N; i++) begin
                da_q[i] <= '0;
                dl_q[i] <= '0;
                dk_q[i] <= 1'b0;
            end
        end else begin
            r_q  <= r_d;
            da_q <= da_d;
            dl_q <= dl_d;
            dk_q <= dk_d;
        end
    end

    // read mux
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == REG_AW'(OFS_STAT)) begin
            cfg_rdata[ST_BUSY] = busy;
            cfg_rdata[ST_DONE] = r_q.done;
            cfg_rdata[ST_ERR]  = r_q.err;
            cfg_rdata[ST_OVR]  = r_q.ovr;
        end
        if (cfg_addr == REG_AW'(OFS_ADDR)) cfg_rdata = 32'(r_q.addr);
        if (cfg_addr == REG_AW'(OFS_LEN))  cfg_rdata = 32'(r_q.len);
        if (cfg_addr == REG_AW'(OFS_CNT))  cfg_rdata = 32'(moved);
        for (int i = 0; i < DESC_N; i++) begin
            if (cfg_addr == REG_AW'(OFS_DESC + 2*i)) cfg_rdata = 32'(da_q[i]);
            if (cfg_addr == REG_AW'(OFS_DESC + 2*i + 1)) begin
                cfg_rdata           = 32'(dl_q[i]);
                cfg_rdata[DSC_STOP] = dk_q[i];
            end
        end
    end

    // entry the engine is about to load
    always_comb begin
        if (chain_mode) begin
            d_addr = da_q[sel_idx];
            d_len  = dl_q[sel_idx];
            d_stop = dk_q[sel_idx];
        end else begin
            d_addr = r_q.addr;
            d_len  = r_q.len;
            d_stop = 1'b1;
        end
    end

    assign irq = r_q.done | r_q.err;

    a_r10_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_addr == REG_AW'(OFS_CTRL) && cfg_wdata[CTL_GO] && busy |=> r_q.ovr);
    a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(cfg_wr && cfg_addr == REG_AW'(OFS_STAT)) |=> irq);
    a_r6_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> irq);
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 16,
    parameter int DESC_N  = 4,
    parameter int IDX_W   = 2,
    parameter int WC_W    = 15,
    parameter int CNT_W   = 17,
    parameter int BYTE_SH = 2,
    parameter int OFS_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_dir,
    input  logic              start_chain,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              chain_mode,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [LEN_W-1:0]  d_len,
    input  logic              d_stop,
    output logic [OFS_W-1:0]  page_ofs,
    output logic [WC_W-1:0]   rem_words,
    input  logic [WC_W-1:0]   chunk_words,
    output logic              busy,
    output logic              done_set,
    output logic              err_set,
    output logic [CNT_W-1:0]  moved,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_first,
    output logic [WC_W-1:0]   mem_blen,
    input  logic              mem_gnt,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_ready
);
    import dma_pkg::*;

    localparam int WORD_BYTES = DATA_W / 8;

    typedef struct packed {
        eng_state_t        st;
        logic              dir;
        logic              chain;
        logic [IDX_W-1:0]  idx;
        logic              stop;
        logic [ADDR_W-1:0] addr;
        logic [WC_W-1:0]   rem;
        logic [WC_W-1:0]   blen;
        logic [WC_W-1:0]   bleft;
        logic              first;
        logic [DATA_W-1:0] hold;
        logic [CNT_W-1:0]  cnt;
    } eng_t;

    eng_t              e_d, e_q;
    logic              step;
    logic [LEN_W-1:0]  len_words;

    assign len_words = d_len >> BYTE_SH;

    always_comb begin
        e_d      = e_q;
        step     = 1'b0;
        done_set = 1'b0;
        err_set  = 1'b0;
        case (e_q.st)
            S_IDLE: if (start) begin
                e_d.st    = S_LOAD;
                e_d.dir   = start_dir;
                e_d.chain = start_chain;
                e_d.idx   = '0;
                e_d.cnt   = '0;
            end
            S_LOAD: begin
                e_d.addr = {d_addr[ADDR_W-1:BYTE_SH], {BYTE_SH{1'b0}}};
                e_d.rem  = WC_W'(len_words);
                e_d.stop = d_stop;
                if (len_words == '0) begin
                    err_set  = 1'b1;
                    e_d.st   = S_IDLE;
                end else begin
                    e_d.st   = S_CHUNK;
                end
            end
            S_CHUNK: begin
                e_d.blen  = chunk_words;
                e_d.bleft = chunk_words;
                e_d.first = 1'b1;
                e_d.st    = e_q.dir ? S_DIN : S_RD;
            end
            S_RD: if (mem_gnt) begin
                if (mem_err) begin
                    err_set  = 1'b1;
                    e_d.st   = S_IDLE;
                end else begin
                    e_d.hold = mem_rdata;
                    e_d.st   = S_DOUT;
                end
            end
            S_DOUT: step = dev_out_ready;
            S_DIN: if (dev_in_valid) begin
                e_d.hold = dev_in_data;
                e_d.st   = S_WR;
            end
            S_WR: if (mem_gnt) begin
                if (mem_err) begin
                    err_set  = 1'b1;
                    e_d.st   = S_IDLE;
                end else begin
                    step     = 1'b1;
                end
            end
            S_NEXT: begin
                if (!e_q.chain || e_q.stop || e_q.idx == IDX_W'(DESC_N - 1)) begin
                    done_set = 1'b1;
                    e_d.st   = S_IDLE;
                end else begin
                    e_d.idx  = e_q.idx + 1'b1;
                    e_d.st   = S_LOAD;
                end
            end
            default: e_d.st = S_IDLE;
        endcase

        if (step) begin
            e_d.addr  = e_q.addr + ADDR_W'(WORD_BYTES);
            e_d.rem   = e_q.rem - 1'b1;
            e_d.bleft = e_q.bleft - 1'b1;
            e_d.cnt   = e_q.cnt + 1'b1;
            e_d.first = 1'b0;
            if (e_q.rem == WC_W'(1))        e_d.st = S_NEXT;
            else if (e_q.bleft == WC_W'(1)) e_d.st = S_CHUNK;
            else                            e_d.st = e_q.dir ? S_DIN : S_RD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= S_IDLE;
        end else begin
            e_q    <= e_d;
        end
    end

    assign busy          = (e_q.st != S_IDLE);
    assign mem_req       = (e_q.st == S_RD) || (e_q.st == S_WR);
    assign mem_we        = (e_q.st == S_WR);
    assign mem_addr      = e_q.addr;
    assign mem_wdata     = e_q.hold;
    assign mem_first     = e_q.first && mem_req;
    assign mem_blen      = e_q.blen;
    assign dev_out_valid = (e_q.st == S_DOUT);
    assign dev_out_data  = e_q.hold;
    assign dev_in_ready  = (e_q.st == S_DIN);
    assign sel_idx       = e_q.idx;
    assign chain_mode    = e_q.chain;
    assign page_ofs      = e_q.addr[OFS_W+BYTE_SH-1:BYTE_SH];
    assign rem_words     = e_q.rem;
    assign moved         = e_q.cnt;

    a_r4_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_first |-> (int'(page_ofs) + int'(mem_blen)) <= (1 << OFS_W));
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    a_r2_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data));
    a_r7_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt && mem_err |=> !busy && !mem_req);
    a_r8_zero_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.st == S_LOAD && len_words == '0 |=> !mem_req && !busy);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> !busy);
endmodule

// File: rtl/dma_chain_top.sv
module dma_chain_top #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 4096,
    parameter int DESC_N     = 4,
    parameter int BYTE_SH    = $clog2(DATA_W / 8),
    parameter int WC_W       = LEN_W - BYTE_SH + 1,
    parameter int REG_AW     = $clog2(8 + 2 * DESC_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_first,
    output logic [WC_W-1:0]   mem_blen,
    input  logic              mem_gnt,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_ready
);
    localparam int IDX_W = (DESC_N > 1) ? $clog2(DESC_N) : 1;
    localparam int CNT_W = WC_W + IDX_W;
    localparam int OFS_W = $clog2(PAGE_BYTES) - BYTE_SH;

    logic              busy, done_set, err_set, start, start_dir, start_chain;
    logic              chain_mode, d_stop;
    logic [CNT_W-1:0]  moved;
    logic [IDX_W-1:0]  sel_idx;
    logic [ADDR_W-1:0] d_addr;
    logic [LEN_W-1:0]  d_len;
    logic [OFS_W-1:0]  page_ofs;
    logic [WC_W-1:0]   rem_words, chunk_words;

    dma_regs #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DESC_N(DESC_N),
        .IDX_W(IDX_W), .REG_AW(REG_AW), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .busy(busy), .done_set(done_set), .err_set(err_set), .moved(moved),
        .sel_idx(sel_idx), .chain_mode(chain_mode),
        .start(start), .start_dir(start_dir), .start_chain(start_chain),
        .d_addr(d_addr), .d_len(d_len), .d_stop(d_stop), .irq(irq)
    );

    dma_chunk #(.OFS_W(OFS_W), .WC_W(WC_W)) u_chunk (
        .page_ofs(page_ofs), .rem_words(rem_words), .chunk_words(chunk_words)
    );

    dma_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DESC_N(DESC_N),
        .IDX_W(IDX_W), .WC_W(WC_W), .CNT_W(CNT_W), .BYTE_SH(BYTE_SH), .OFS_W(OFS_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_dir(start_dir), .start_chain(start_chain),
        .sel_idx(sel_idx), .chain_mode(chain_mode),
        .d_addr(d_addr), .d_len(d_len), .d_stop(d_stop),
        .page_ofs(page_ofs), .rem_words(rem_words), .chunk_words(chunk_words),
        .busy(busy), .done_set(done_set), .err_set(err_set), .moved(moved),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_first(mem_first), .mem_blen(mem_blen),
        .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready)
    );
endmodule

// File: tb/dma_chain_top_tb.sv
module dma_chain_top_tb;
    localparam logic [31:0] RD_MASK = 32'h5A5A_0000;
    localparam logic [31:0] IN_BASE = 32'hD000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq, mem_req, mem_we, mem_first;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [14:0] mem_blen;
    logic        mem_gnt = 1'b0;
    logic        mem_err;
    logic        dev_out_valid, dev_in_ready;
    logic [31:0] dev_out_data;
    logic        dev_out_ready = 1'b0;
    logic        dev_in_valid = 1'b0;
    logic [31:0] dev_in_data = IN_BASE;
    logic        err_en = 1'b0;
    logic [31:0] err_at = '0;

    always #10 clk = ~clk;

    assign mem_rdata = mem_addr ^ RD_MASK;
    assign mem_err   = err_en && (mem_addr == err_at);

    dma_chain_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_first(mem_first), .mem_blen(mem_blen), .mem_gnt(mem_gnt), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_ready(dev_in_ready)
    );

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic        first;
        logic [14:0] blen;
        logic [31:0] wd;
    } beat_t;

    beat_t       exp_q[$];
    logic [31:0] dev_q[$];
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    int          dev_word = 0;
    int          dev_exp = 0;
    bit          in_hs = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // stall patterns, driven after the edge
    always @(posedge clk) begin
        #2;
        cyc++;
        mem_gnt       = (cyc % 3) != 1;
        dev_out_ready = (cyc % 4) != 2;
        dev_in_valid  = (cyc % 5) != 3;
        if (in_hs) begin
            dev_word++;
            in_hs = 0;
        end
        dev_in_data = IN_BASE + 32'(dev_word);
    end

    // monitor: pops expected items at each handshake
    always @(negedge clk) begin
        beat_t b;
        logic [31:0] dv;
        if (rst_n) begin
            if (mem_req && mem_gnt) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R5 unexpected beat act=%h exp=none", mem_addr);
                end else begin
                    b = exp_q.pop_front();
                    check("R2 mem_addr", mem_addr, b.addr);
                    check("R3 mem_we", 32'(mem_we), 32'(b.we));
                    check("R4 mem_first", 32'(mem_first), 32'(b.first));
                    if (b.first) check("R4 mem_blen", 32'(mem_blen), 32'(b.blen));
                    if (b.we) check("R3 mem_wdata", mem_wdata, b.wd);
                end
            end
            if (dev_out_valid && dev_out_ready) begin
                if (dev_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R2 unexpected dev word act=%h exp=none", dev_out_data);
                end else begin
                    dv = dev_q.pop_front();
                    check("R2 dev_out_data", dev_out_data, dv);
                end
            end
            if (dev_in_valid && dev_in_ready) in_hs = 1;
        end
    end

    // driver: expected beats of one entry, split at page edges
    task automatic push_entry(input logic [31:0] a, input int bytes, input logic dir,
                              input bit use_err, input logic [31:0] e_at);
        int rem;
        logic [31:0] p;
        rem = bytes / 4;
        p   = a & ~32'h3;
        while (rem > 0) begin
            int to_pg;
            int ch;
            to_pg = (4096 - int'(p % 4096)) / 4;
            ch    = (rem < to_pg) ? rem : to_pg;
            for (int k = 0; k < ch; k++) begin
                beat_t b;
                b.addr  = p;
                b.we    = dir;
                b.first = (k == 0);
                b.blen  = 15'(ch);
                b.wd    = IN_BASE + 32'(dev_exp);
                exp_q.push_back(b);
                if (use_err && p == e_at) return;
                if (dir) dev_exp++;
                else dev_q.push_back(p ^ RD_MASK);
                p = p + 4;
                rem--;
            end
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #3;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #3;
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #3;
        cfg_addr = a;
        @(negedge clk);
        d = cfg_rdata;
    endtask

    task automatic wait_irq(input string tag);
        int n;
        n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(tag, 32'(irq), 32'd1);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 mem_req", 32'(mem_req), 32'd0);
        check("R1 dev_out_valid", 32'(dev_out_valid), 32'd0);
        rd(4'd1, v);
        check("R1 status", v, 32'h0);

        // A: single mode, memory to device, crosses 0x1000
        push_entry(32'h0000_0FF0, 48, 1'b0, 1'b0, '0);
        wr(4'd2, 32'h0000_0FF0);
        wr(4'd3, 32'd48);
        wr(4'd0, 32'h1);
        wait_irq("R6 irq after single read");
        rd(4'd1, v);
        check("R6 status done", v, 32'h2);
        rd(4'd4, v);
        check("R2 moved words", v, 32'd12);
        check("R2 queue drained", 32'(exp_q.size() + dev_q.size()), 32'd0);
        repeat (10) @(negedge clk);
        check("R9 irq held", 32'(irq), 32'd1);
        wr(4'd1, 32'h2);
        @(negedge clk);
        check("R9 irq cleared", 32'(irq), 32'd0);

        // B: single mode, device to memory, crosses 0x3000
        push_entry(32'h0000_2FF8, 16, 1'b1, 1'b0, '0);
        wr(4'd2, 32'h0000_2FF8);
        wr(4'd3, 32'd16);
        wr(4'd0, 32'h3);
        wait_irq("R6 irq after write");
        rd(4'd4, v);
        check("R3 moved words", v, 32'd4);
        check("R3 queue drained", 32'(exp_q.size()), 32'd0);
        wr(4'd1, 32'h2);

        // C: chain of three, spare fourth entry must not run; go while busy
        wr(4'd8,  32'h0000_3FF8); wr(4'd9,  32'd16);
        wr(4'd10, 32'h0000_8000); wr(4'd11, 32'd8);
        wr(4'd12, 32'h0000_1000); wr(4'd13, 32'h8000_0004);
        wr(4'd14, 32'h0000_9000); wr(4'd15, 32'h8000_0008);
        push_entry(32'h0000_3FF8, 16, 1'b0, 1'b0, '0);
        push_entry(32'h0000_8000, 8,  1'b0, 1'b0, '0);
        push_entry(32'h0000_1000, 4,  1'b0, 1'b0, '0);
        wr(4'd0, 32'h5);
        wr(4'd0, 32'h5);
        wait_irq("R5 irq after chain");
        repeat (20) @(negedge clk);
        rd(4'd1, v);
        check("R10 status done+overrun", v, 32'hA);
        rd(4'd4, v);
        check("R5 chain moved words", v, 32'd7);
        check("R5 chain queue drained", 32'(exp_q.size() + dev_q.size()), 32'd0);
        wr(4'd1, 32'hA);
        rd(4'd1, v);
        check("R10 overrun cleared", v, 32'h0);

        // D: memory error on the third beat
        err_en = 1'b1; err_at = 32'h0000_5008;
        push_entry(32'h0000_5000, 16, 1'b0, 1'b1, 32'h0000_5008);
        wr(4'd2, 32'h0000_5000);
        wr(4'd3, 32'd16);
        wr(4'd0, 32'h1);
        wait_irq("R7 irq on error");
        repeat (20) @(negedge clk);
        check("R7 no request after error", 32'(mem_req), 32'd0);
        rd(4'd1, v);
        check("R7 status error only", v, 32'h4);
        rd(4'd4, v);
        check("R7 moved before error", v, 32'd2);
        check("R7 queue drained", 32'(exp_q.size() + dev_q.size()), 32'd0);
        err_en = 1'b0;
        wr(4'd1, 32'h4);
        @(negedge clk);
        check("R9 irq cleared after error", 32'(irq), 32'd0);

        // E: zero-word entry in chain mode
        wr(4'd9, 32'd2);
        wr(4'd0, 32'h5);
        wait_irq("R8 irq on zero length");
        rd(4'd1, v);
        check("R8 status error", v, 32'h4);
        rd(4'd4, v);
        check("R8 nothing moved", v, 32'd0);
        wr(4'd1, 32'h4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule